// File: doc/BRIEF.md
# Branch Target Buffer with Direction Bits

This block sits beside the fetch stage and answers one question on every cycle: where should fetch go next? The current fetch address picks one slot of a direct-mapped table. A slot holds a valid flag, the upper bits of the branch address that wrote it, the address that branch jumped to, and a two-bit saturating direction counter. The stored address bits must match the fetch address exactly before the slot counts. A target left behind by a different branch that shares the slot is never followed. A match whose counter leans taken sends fetch to the stored target. Every other case sends fetch to the next sequential word, the fetch address plus four.

The execute stage reports each resolved branch on a separate resolve port. It gives the branch address, whether the branch was taken, and its taken-path target. A report that matches its slot trains the counter and refreshes the stored target. A taken branch that does not match claims the slot, and any earlier occupant is lost. A not-taken branch that does not match leaves the table untouched.

The lookup is purely combinational. The resolve port has no back-pressure. One report per cycle is always absorbed on the next rising edge, so there is no ready signal, and a report with `res_valid` low is ignored.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every slot is invalid, so every lookup gives `pred_hit`=0, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R2: A lookup whose slot is invalid, or whose stored tag differs from the fetch address tag, gives `pred_hit`=0 and `next_pc`=`fetch_pc`+4 (modulo 2^ADDR_W).
- R3: A lookup that matches a slot whose counter has bit 1 set (encodings 2'b10 weakly taken and 2'b11 strongly taken) gives `pred_hit`=1, `pred_taken`=1 and `next_pc` equal to the stored target.
- R4: A lookup that matches a slot whose counter has bit 1 clear (2'b00 strongly not taken, 2'b01 weakly not taken) gives `pred_hit`=1, `pred_taken`=0 and `next_pc`=`fetch_pc`+4.
- R5: A valid taken resolve that misses writes its tag and target into the slot and sets the counter to weakly taken (2'b10).
- R6: A valid not-taken resolve that misses changes nothing in the table.
- R7: A valid resolve that hits moves the counter one step toward taken (if taken) or toward not taken (if not), holding at 2'b11 and 2'b00.
- R8: A valid resolve that hits replaces the stored target with the reported target.
- R9: Slot index is fetch address bits [IDX_W+1:2] and the tag is bits [ADDR_W-1:IDX_W+2]. Two addresses that share an index but differ in tag never hit on each other's slot, and a taken miss from one evicts the other.
- R10: A resolve takes effect only at the next rising clock edge; a lookup in the same cycle sees the table as it was before the resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address being fetched this cycle |
| pred_hit | output | 1 | Fetch address matched a valid slot |
| pred_taken | output | 1 | Match with a taken-leaning counter |
| next_pc | output | ADDR_W | Address to fetch next |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | ADDR_W | Address of the resolved branch |
| res_taken | input | 1 | Resolved branch was taken |
| res_target | input | ADDR_W | Taken-path target of the resolved branch |

## Verification
The hardest states to reach from the ports are those where two branches fight over one slot. Here a stored target must be refused because only the tag differs, and an eviction must follow a taken miss. Counters pinned at either rail are a second case, since only a further resolve in the same direction shows them holding. The random phase draws fetch and resolve addresses from a small pool with several index collisions, so hits, aliases and evictions recur. The directed phase walks one slot through every counter value, both rails included, and places a resolve and a lookup of the same address in one cycle.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    DIR_STRONG_NT = 2'b00,
    DIR_WEAK_NT   = 2'b01,
    DIR_WEAK_T    = 2'b10,
    DIR_STRONG_T  = 2'b11
  } dir_cnt_e;

  // Saturating one-step move of a direction counter.
  function automatic dir_cnt_e dir_step(input dir_cnt_e cur, input logic taken);
    dir_cnt_e nxt;
    unique case (cur)
      DIR_STRONG_NT: nxt = taken ? DIR_WEAK_NT  : DIR_STRONG_NT;
      DIR_WEAK_NT:   nxt = taken ? DIR_WEAK_T   : DIR_STRONG_NT;
      DIR_WEAK_T:    nxt = taken ? DIR_STRONG_T : DIR_WEAK_NT;
      default:       nxt = taken ? DIR_STRONG_T : DIR_WEAK_T;
    endcase
    return nxt;
  endfunction

  function automatic logic dir_says_taken(input dir_cnt_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // fetch-side read port
  input  logic [IDX_W-1:0]  fr_idx,
  output logic              fr_valid,
  output logic [TAG_W-1:0]  fr_tag,
  output logic [ADDR_W-1:0] fr_tgt,
  output dir_cnt_e          fr_cnt,
  // resolve-side read port
  input  logic [IDX_W-1:0]  rr_idx,
  output logic              rr_valid,
  output logic [TAG_W-1:0]  rr_tag,
  output dir_cnt_e          rr_cnt,
  // write port
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_tgt,
  input  dir_cnt_e          wr_cnt
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  dir_cnt_e           cnt_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (sel) begin
        valid_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        tag_q[g] <= wr_tag;
        tgt_q[g] <= wr_tgt;
        cnt_q[g] <= wr_cnt;
      end
    end
  end

  always_comb begin
    fr_valid = valid_q[fr_idx];
    fr_tag   = tag_q[fr_idx];
    fr_tgt   = tgt_q[fr_idx];
    fr_cnt   = cnt_q[fr_idx];
    rr_valid = valid_q[rr_idx];
    rr_tag   = tag_q[rr_idx];
    rr_cnt   = cnt_q[rr_idx];
  end

  // R1: coming out of reset, nothing is valid
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (valid_q == '0));

  // R10: without a write, the valid set holds across the edge
  assert_quiet_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(valid_q));

  // R10: a write shows up exactly after the edge
  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (valid_q[$past(wr_idx)] && tgt_q[$past(wr_idx)] == $past(wr_tgt)));

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [IDX_W-1:0]  fr_idx,
  input  logic              fr_valid,
  input  logic [TAG_W-1:0]  fr_tag,
  input  logic [ADDR_W-1:0] fr_tgt,
  input  dir_cnt_e          fr_cnt,
  output logic              hit,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);

  logic [TAG_W-1:0]  pc_tag;
  logic [ADDR_W-1:0] seq_pc;
  logic [1:0]        unused_fetch_low;

  assign fr_idx           = fetch_pc[IDX_W+1:2];
  assign pc_tag           = fetch_pc[ADDR_W-1:IDX_W+2];
  assign unused_fetch_low = fetch_pc[1:0];
  assign seq_pc           = fetch_pc + ADDR_W'(4);

  always_comb begin
    hit     = fr_valid && (fr_tag == pc_tag);
    taken   = hit && dir_says_taken(fr_cnt);
    next_pc = taken ? fr_tgt : seq_pc;
  end

  // R2: no match means sequential fetch
  assert_miss_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (next_pc == fetch_pc + ADDR_W'(4)));

  // R3: a redirect only happens on a confirmed match
  assert_redirect_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (next_pc != fetch_pc + ADDR_W'(4)) |-> (hit && taken));

  // R4: a not-taken match keeps sequential fetch
  assert_hit_nt_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !fr_cnt[1]) |-> (!taken && next_pc == fetch_pc + ADDR_W'(4)));

endmodule

// File: rtl/btb_train.sv
module btb_train
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic [IDX_W-1:0]  rr_idx,
  input  logic              rr_valid,
  input  logic [TAG_W-1:0]  rr_tag,
  input  dir_cnt_e          rr_cnt,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [ADDR_W-1:0] wr_tgt,
  output dir_cnt_e          wr_cnt
);

  logic [TAG_W-1:0] res_tag;
  logic             res_hit;
  logic [1:0]       unused_res_low;

  assign rr_idx         = res_pc[IDX_W+1:2];
  assign res_tag        = res_pc[ADDR_W-1:IDX_W+2];
  assign unused_res_low = res_pc[1:0];

  always_comb begin
    res_hit = rr_valid && (rr_tag == res_tag);
    wr_en   = res_valid && (res_hit || res_taken);
    wr_idx  = rr_idx;
    wr_tag  = res_tag;
    wr_tgt  = res_target;
    wr_cnt  = res_hit ? dir_step(rr_cnt, res_taken) : DIR_WEAK_T;
  end

  // R5: a fresh allocation starts weakly taken
  assert_alloc_weak_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(rr_valid && rr_tag == res_tag)) |-> (wr_cnt == DIR_WEAK_T && res_taken));

  // R6: a not-taken miss never writes
  assert_nt_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_taken && !(rr_valid && rr_tag == res_tag)) |-> !wr_en);

  // R7: counters hold at both rails
  assert_sat_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && res_hit && rr_cnt == DIR_STRONG_T && res_taken) |-> (wr_cnt == DIR_STRONG_T));
  assert_sat_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && res_hit && rr_cnt == DIR_STRONG_NT && !res_taken) |-> (wr_cnt == DIR_STRONG_NT));

  // R8: a hitting resolve always writes the reported target
  assert_hit_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (wr_en && wr_tgt == res_target));

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] next_pc,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target
);

  logic [IDX_W-1:0]  fr_idx, rr_idx, wr_idx;
  logic              fr_valid, rr_valid, wr_en;
  logic [TAG_W-1:0]  fr_tag, rr_tag, wr_tag;
  logic [ADDR_W-1:0] fr_tgt, wr_tgt;
  dir_cnt_e          fr_cnt, rr_cnt, wr_cnt;

  btb_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) store_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fr_idx   (fr_idx),
    .fr_valid (fr_valid),
    .fr_tag   (fr_tag),
    .fr_tgt   (fr_tgt),
    .fr_cnt   (fr_cnt),
    .rr_idx   (rr_idx),
    .rr_valid (rr_valid),
    .rr_tag   (rr_tag),
    .rr_cnt   (rr_cnt),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_tag   (wr_tag),
    .wr_tgt   (wr_tgt),
    .wr_cnt   (wr_cnt)
  );

  btb_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) lookup_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fetch_pc (fetch_pc),
    .fr_idx   (fr_idx),
    .fr_valid (fr_valid),
    .fr_tag   (fr_tag),
    .fr_tgt   (fr_tgt),
    .fr_cnt   (fr_cnt),
    .hit      (pred_hit),
    .taken    (pred_taken),
    .next_pc  (next_pc)
  );

  btb_train #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) train_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .res_valid  (res_valid),
    .res_pc     (res_pc),
    .res_taken  (res_taken),
    .res_target (res_target),
    .rr_idx     (rr_idx),
    .rr_valid   (rr_valid),
    .rr_tag     (rr_tag),
    .rr_cnt     (rr_cnt),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_tag     (wr_tag),
    .wr_tgt     (wr_tgt),
    .wr_cnt     (wr_cnt)
  );

  // R9: an aliasing address with a different tag is never a hit
  assert_alias_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_valid && fr_tag != fetch_pc[ADDR_W-1:IDX_W+2]) |-> (!pred_hit && !pred_taken));

endmodule

// File: tb/branch_target_buffer_tb_top.sv
module branch_target_buffer_tb_top;
  localparam int ENTRIES = 16;
  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 4;
  localparam int TAG_W   = ADDR_W - IDX_W - 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] fetch_pc = '0;
  logic              pred_hit, pred_taken;
  logic [ADDR_W-1:0] next_pc;
  logic              res_valid = 1'b0;
  logic [ADDR_W-1:0] res_pc = '0;
  logic              res_taken = 1'b0;
  logic [ADDR_W-1:0] res_target = '0;

  always #4 clk = ~clk;

  branch_target_buffer #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .next_pc(next_pc),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_target(res_target)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference table
  bit               m_valid [ENTRIES];
  logic [TAG_W-1:0] m_tag   [ENTRIES];
  logic [ADDR_W-1:0] m_tgt  [ENTRIES];
  logic [1:0]       m_cnt   [ENTRIES];

  function automatic int idx_of(logic [ADDR_W-1:0] a);
    return int'(a[IDX_W+1:2]);
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W+2];
  endfunction

  function automatic bit exp_hit(logic [ADDR_W-1:0] a);
    return m_valid[idx_of(a)] && (m_tag[idx_of(a)] == tag_of(a));
  endfunction

  function automatic bit exp_taken(logic [ADDR_W-1:0] a);
    return exp_hit(a) && m_cnt[idx_of(a)][1];
  endfunction

  function automatic logic [ADDR_W-1:0] exp_next(logic [ADDR_W-1:0] a);
    return exp_taken(a) ? m_tgt[idx_of(a)] : a + 32'd4;
  endfunction

  function automatic logic [1:0] sat_move(logic [1:0] c, bit t);
    if (t) return (c == 2'b11) ? 2'b11 : c + 2'b01;
    return (c == 2'b00) ? 2'b00 : c - 2'b01;
  endfunction

  task automatic model_update(bit v, logic [ADDR_W-1:0] pc, bit t, logic [ADDR_W-1:0] tgt);
    int i;
    i = idx_of(pc);
    if (!v) return;
    if (exp_hit(pc)) begin
      m_cnt[i] = sat_move(m_cnt[i], t);
      m_tgt[i] = tgt;
    end else if (t) begin
      m_valid[i] = 1'b1;
      m_tag[i]   = tag_of(pc);
      m_tgt[i]   = tgt;
      m_cnt[i]   = 2'b10;
    end
  endtask

  task automatic check(string req, string what, logic [ADDR_W-1:0] act, logic [ADDR_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, compare the combinational answer, then let the edge commit.
  task automatic step(string req, logic [ADDR_W-1:0] fpc, bit rv,
                      logic [ADDR_W-1:0] rpc, bit rt, logic [ADDR_W-1:0] rtgt);
    string r;
    @(negedge clk);
    fetch_pc   = fpc;
    res_valid  = rv;
    res_pc     = rpc;
    res_taken  = rt;
    res_target = rtgt;
    #1;
    r = req;
    if (r == "") r = !exp_hit(fpc) ? "R2" : (exp_taken(fpc) ? "R3" : "R4");
    check(r, "pred_hit",   {31'd0, pred_hit},   {31'd0, exp_hit(fpc)});
    check(r, "pred_taken", {31'd0, pred_taken}, {31'd0, exp_taken(fpc)});
    check(r, "next_pc",    next_pc,             exp_next(fpc));
    @(posedge clk);
    model_update(rv, rpc, rt, rtgt);
  endtask

  task automatic look(string req, logic [ADDR_W-1:0] fpc);
    step(req, fpc, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic resolve(string req, logic [ADDR_W-1:0] pc, bit t, logic [ADDR_W-1:0] tgt);
    step(req, pc, 1'b1, pc, t, tgt);
  endtask

  localparam logic [ADDR_W-1:0] PA = 32'h0000_1000; // index 0
  localparam logic [ADDR_W-1:0] PB = 32'h0000_1040; // index 0, other tag
  localparam logic [ADDR_W-1:0] TA = 32'h0000_4000;
  localparam logic [ADDR_W-1:0] TB = 32'h0000_8000;

  logic [ADDR_W-1:0] pool [8];

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < ENTRIES; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_cnt[i] = 2'b00;
    end
    pool[0] = PA;             pool[1] = PB;
    pool[2] = 32'h0000_2004;  pool[3] = 32'h0000_3044;
    pool[4] = 32'h0000_5008;  pool[5] = 32'hFFFF_FFFC;
    pool[6] = 32'h0000_203C;  pool[7] = 32'h0000_2004 + 32'h0000_0400;

    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    look("R1", PA);
    look("R1", 32'hFFFF_FFFC);  // also sequential wrap, R2
    look("R1", 32'h0000_2004);

    // R6: not-taken miss allocates nothing
    resolve("R6", PA, 1'b0, TA);
    look("R6", PA);

    // R10: taken resolve while PA is looked up; same-cycle lookup still misses
    resolve("R10", PA, 1'b1, TA);
    // R5 + R3: allocated weakly taken, redirects
    look("R5", PA);
    // R9: alias on index 0 does not hit
    look("R9", PB);
    // R7/R4: one not-taken -> weakly not taken
    resolve("R7", PA, 1'b0, TA);
    look("R4", PA);
    resolve("R7", PA, 1'b0, TA);
    resolve("R7", PA, 1'b0, TA);   // held at strong not taken
    resolve("R7", PA, 1'b1, TA);   // up to weakly not taken only
    look("R7", PA);
    resolve("R7", PA, 1'b1, TA);
    resolve("R7", PA, 1'b1, TA);
    resolve("R7", PA, 1'b1, TA);   // held at strong taken
    resolve("R7", PA, 1'b0, TA);   // down to weakly taken, still redirects
    look("R7", PA);
    // R8: target refresh on hit
    resolve("R8", PA, 1'b1, TB);
    look("R8", PA);
    // R9: alias taken miss evicts the old occupant
    resolve("R9", PB, 1'b1, TA);
    look("R9", PA);
    look("R9", PB);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      logic [ADDR_W-1:0] f, r, t;
      f = ($urandom % 4 == 0) ? {$urandom} & 32'hFFFF_FFFC : pool[$urandom % 8];
      r = pool[$urandom % 8];
      t = {$urandom} & 32'h000F_FFFC;
      step("", f, ($urandom % 3) != 0, r, $urandom % 2, t);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule